// File: doc/BRIEF.md
# Dual-Bank Bidirectional Latched Transceiver

This block carries data between two 16-bit ports, A and B. Each port can drive data in either direction through a bank of latches. The 16 bits are split into two independent 8-bit halves. Each half has its own latch bank for A-to-B traffic and another for B-to-A traffic. Every direction of every half is steered by three active-low controls:

- an enable, which gates both loading and driving;
- a latch enable, which makes the latch transparent while low;
- an output enable.

The latches are modelled with a clock. A latch that is transparent passes its input straight to the far port in the same cycle, and it records that input at every rising clock edge. When the latch enable returns high, the latch keeps the value it recorded at the last edge while it was transparent. The bidirectional pins are split into separate signals:

- an input value and a per-bit "driven" flag;
- an output value and a per-bit output enable.

Undriven output data reads as zero. With the bus-hold parameter set, an input bit whose driven flag is low behaves as if it still carried the last value that was driven on it. The latch capture path reads only the external input buses, so a port never records the value the block itself is driving onto it.

Top module: `dual_bank_xcvr`

## Requirements
- R1: While a half's A-to-B enable and latch enable are both low and its output enable is low, that half's B output follows the effective A input in the same cycle.
- R2: After the latch enable of a direction rises, the half drives the value that its input held at the last clock edge at which the latch was transparent, and ignores later input changes.
- R3: While a direction's enable is high, its latch holds its contents and its output enable bits are all 0, whatever the other two controls are.
- R4: While a direction's latch enable is high, its latch holds its contents whatever the enable and output enable levels are; with enable and output enable low, the stored value is driven.
- R5: While a direction's output enable is high, its output enable bits are 0 and its output data bits read 0.
- R6: B-to-A traffic obeys R1 to R5 using its own three controls, with B as the source and A as the destination.
- R7: The two 8-bit halves (bits 7:0 with control bit 0, bits 15:8 with control bit 1) behave independently of each other.
- R8: With BUS_HOLD=1, an input bit whose driven flag is 0 takes the last value it had while its flag was 1, or 0 if it was never driven since reset.
- R9: During reset all output enable bits are 0, whatever the controls are. After reset all latches read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_ce_n | input | NHALF | A-to-B enable per half, active low |
| ab_le_n | input | NHALF | A-to-B latch enable per half, active low |
| ab_oe_n | input | NHALF | A-to-B output enable per half, active low |
| ba_ce_n | input | NHALF | B-to-A enable per half, active low |
| ba_le_n | input | NHALF | B-to-A latch enable per half, active low |
| ba_oe_n | input | NHALF | B-to-A output enable per half, active low |
| a_in | input | NHALF*HW | Value on the A pins from outside |
| a_vld | input | NHALF*HW | Per-bit flag: A pin driven from outside |
| b_in | input | NHALF*HW | Value on the B pins from outside |
| b_vld | input | NHALF*HW | Per-bit flag: B pin driven from outside |
| a_out | output | NHALF*HW | Data the block drives onto A |
| a_oe | output | NHALF*HW | Per-bit drive enable for A |
| b_out | output | NHALF*HW | Data the block drives onto B |
| b_oe | output | NHALF*HW | Per-bit drive enable for B |

## Verification
The hardest situation to reach is a latch that was loaded through the bus-hold path, that is, while its source bits were undriven. The latch must then keep that held value after its latch enable rises and show it only later, once the output enable drops. Random stimulus clears each driven flag with a probability of one in four and draws all six controls of both halves freshly every cycle, so such sequences arise on their own. A directed case also walks through them explicitly. Further directed cases cover a capture followed by input changes, and one half transparent while the other stores.

// File: rtl/dual_bank_xcvr.sv
module dual_bank_xcvr #(
  parameter int HW       = 8,
  parameter int NHALF    = 2,
  parameter bit BUS_HOLD = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NHALF-1:0]      ab_ce_n,
  input  logic [NHALF-1:0]      ab_le_n,
  input  logic [NHALF-1:0]      ab_oe_n,
  input  logic [NHALF-1:0]      ba_ce_n,
  input  logic [NHALF-1:0]      ba_le_n,
  input  logic [NHALF-1:0]      ba_oe_n,
  input  logic [NHALF*HW-1:0]   a_in,
  input  logic [NHALF*HW-1:0]   a_vld,
  input  logic [NHALF*HW-1:0]   b_in,
  input  logic [NHALF*HW-1:0]   b_vld,
  output logic [NHALF*HW-1:0]   a_out,
  output logic [NHALF*HW-1:0]   a_oe,
  output logic [NHALF*HW-1:0]   b_out,
  output logic [NHALF*HW-1:0]   b_oe
);
  localparam int W = NHALF * HW;

  logic [W-1:0] eff_a, eff_b, hold_a, hold_b, q_ab, q_ba;
  logic [NHALF-1:0] t_ab, t_ba, drv_ab, drv_ba;

  assign t_ab   = ~ab_ce_n & ~ab_le_n;
  assign t_ba   = ~ba_ce_n & ~ba_le_n;
  assign drv_ab = {NHALF{rst_n}} & ~ab_ce_n & ~ab_oe_n;
  assign drv_ba = {NHALF{rst_n}} & ~ba_ce_n & ~ba_oe_n;

  generate
    if (BUS_HOLD) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_a <= '0;
          hold_b <= '0;
        end else begin
          hold_a <= eff_a;
          hold_b <= eff_b;
        end
      end
      assign eff_a = (a_vld & a_in) | (~a_vld & hold_a);
      assign eff_b = (b_vld & b_in) | (~b_vld & hold_b);
    end else begin : g_float
      assign hold_a = '0;
      assign hold_b = '0;
      assign eff_a  = a_vld & a_in;
      assign eff_b  = b_vld & b_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ab <= '0;
      q_ba <= '0;
    end else begin
      for (int h = 0; h < NHALF; h++) begin
        if (t_ab[h]) q_ab[h*HW +: HW] <= eff_a[h*HW +: HW];
        if (t_ba[h]) q_ba[h*HW +: HW] <= eff_b[h*HW +: HW];
      end
    end
  end

  always_comb begin
    b_out = '0;
    b_oe  = '0;
    a_out = '0;
    a_oe  = '0;
    for (int h = 0; h < NHALF; h++) begin
      if (drv_ab[h]) begin
        b_oe[h*HW +: HW]  = '1;
        b_out[h*HW +: HW] = t_ab[h] ? eff_a[h*HW +: HW] : q_ab[h*HW +: HW];
      end
      if (drv_ba[h]) begin
        a_oe[h*HW +: HW]  = '1;
        a_out[h*HW +: HW] = t_ba[h] ? eff_b[h*HW +: HW] : q_ba[h*HW +: HW];
      end
    end
  end
endmodule

module dual_bank_xcvr_chk #(
  parameter int HW    = 8,
  parameter int NHALF = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NHALF-1:0]    ab_ce_n,
  input logic [NHALF-1:0]    ab_le_n,
  input logic [NHALF-1:0]    ab_oe_n,
  input logic [NHALF-1:0]    ba_ce_n,
  input logic [NHALF-1:0]    ba_le_n,
  input logic [NHALF-1:0]    ba_oe_n,
  input logic [NHALF*HW-1:0] a_in,
  input logic [NHALF*HW-1:0] a_vld,
  input logic [NHALF*HW-1:0] b_in,
  input logic [NHALF*HW-1:0] b_vld,
  input logic [NHALF*HW-1:0] a_out,
  input logic [NHALF*HW-1:0] a_oe,
  input logic [NHALF*HW-1:0] b_out,
  input logic [NHALF*HW-1:0] b_oe,
  input logic [NHALF*HW-1:0] q_ab,
  input logic [NHALF*HW-1:0] q_ba
);
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    a_r3_ce_blocks_ab: assert property (@(posedge clk) disable iff (!rst_n)
      ab_ce_n[h] |-> b_oe[h*HW +: HW] == '0);
    a_r5_oe_blocks_ab: assert property (@(posedge clk) disable iff (!rst_n)
      ab_oe_n[h] |-> (b_oe[h*HW +: HW] == '0 && b_out[h*HW +: HW] == '0));
    a_r4_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_ce_n[h] || ab_le_n[h]) |=> $stable(q_ab[h*HW +: HW]));
    a_r1_follow_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_ce_n[h] && !ab_le_n[h] && !ab_oe_n[h] && (&a_vld[h*HW +: HW]))
        |-> b_out[h*HW +: HW] == a_in[h*HW +: HW]);
    a_r2_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_ce_n[h] && !ab_le_n[h] && (&a_vld[h*HW +: HW]))
        |=> q_ab[h*HW +: HW] == $past(a_in[h*HW +: HW]));

    a_r6_ce_blocks_ba: assert property (@(posedge clk) disable iff (!rst_n)
      ba_ce_n[h] |-> a_oe[h*HW +: HW] == '0);
    a_r6_oe_blocks_ba: assert property (@(posedge clk) disable iff (!rst_n)
      ba_oe_n[h] |-> (a_oe[h*HW +: HW] == '0 && a_out[h*HW +: HW] == '0));
    a_r6_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_ce_n[h] || ba_le_n[h]) |=> $stable(q_ba[h*HW +: HW]));
    a_r6_follow_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_ce_n[h] && !ba_le_n[h] && !ba_oe_n[h] && (&b_vld[h*HW +: HW]))
        |-> a_out[h*HW +: HW] == b_in[h*HW +: HW]);
    a_r6_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_ce_n[h] && !ba_le_n[h] && (&b_vld[h*HW +: HW]))
        |=> q_ba[h*HW +: HW] == $past(b_in[h*HW +: HW]));
  end
endmodule

bind dual_bank_xcvr dual_bank_xcvr_chk #(.HW(HW), .NHALF(NHALF)) u_chk (.*);

// File: tb/tb_dual_bank_xcvr.sv
module tb_dual_bank_xcvr;
  localparam int PERIOD = 10;
  localparam int HW = 8;
  localparam int NHALF = 2;
  localparam int W = HW * NHALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NHALF-1:0] ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
  logic [W-1:0] a_in, a_vld, b_in, b_vld, a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] mq_ab = '0, mq_ba = '0, mh_a = '0, mh_b = '0;

  always #(PERIOD/2) clk = ~clk;

  dual_bank_xcvr #(.HW(HW), .NHALF(NHALF), .BUS_HOLD(1'b1)) dut (.*);

  task automatic chk(string req, logic [2*HW-1:0] act, logic [2*HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] eff(logic [W-1:0] in, logic [W-1:0] vld, logic [W-1:0] hold);
    return (vld & in) | (~vld & hold);
  endfunction

  function automatic logic [2*HW-1:0] expect_dir(logic ce, logic le, logic oe,
                                                 logic [HW-1:0] e, logic [HW-1:0] q);
    if (ce || oe) return '0;
    return {{HW{1'b1}}, (le ? q : e)};
  endfunction

  function automatic string tag_of(logic ce, logic le, logic oe, logic [HW-1:0] vld);
    if (ce) return "R3";
    if (oe) return "R5";
    if (le) return "R4";
    if (vld != '1) return "R8";
    return "R1";
  endfunction

  task automatic cycle();
    logic [W-1:0] ea, eb;
    #1;
    ea = eff(a_in, a_vld, mh_a);
    eb = eff(b_in, b_vld, mh_b);
    for (int h = 0; h < NHALF; h++) begin
      chk({tag_of(ab_ce_n[h], ab_le_n[h], ab_oe_n[h], a_vld[h*HW +: HW]), " R7 ab"},
          {b_oe[h*HW +: HW], b_out[h*HW +: HW]},
          expect_dir(ab_ce_n[h], ab_le_n[h], ab_oe_n[h], ea[h*HW +: HW], mq_ab[h*HW +: HW]));
      chk({"R6 ", tag_of(ba_ce_n[h], ba_le_n[h], ba_oe_n[h], b_vld[h*HW +: HW]), " ba"},
          {a_oe[h*HW +: HW], a_out[h*HW +: HW]},
          expect_dir(ba_ce_n[h], ba_le_n[h], ba_oe_n[h], eb[h*HW +: HW], mq_ba[h*HW +: HW]));
    end
    for (int h = 0; h < NHALF; h++) begin
      if (!ab_ce_n[h] && !ab_le_n[h]) mq_ab[h*HW +: HW] = ea[h*HW +: HW];
      if (!ba_ce_n[h] && !ba_le_n[h]) mq_ba[h*HW +: HW] = eb[h*HW +: HW];
    end
    mh_a = ea;
    mh_b = eb;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    ab_ce_n = '0; ab_le_n = '0; ab_oe_n = '0;
    ba_ce_n = '0; ba_le_n = '0; ba_oe_n = '0;
    a_in = '1; a_vld = '1; b_in = '1; b_vld = '1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 reset b_oe", {{HW{1'b0}}, b_oe[HW-1:0]}, '0);
    chk("R9 reset a_oe", {a_oe}, '0);
    ab_le_n = '1; ba_le_n = '1;
    rst_n = 1'b1;
    #1;
    chk("R9 cleared ab", {b_out}, '0);
    chk("R9 cleared ba", {a_out}, '0);
    @(negedge clk);

    // R2: capture on latch enable rise, later input changes ignored
    ab_ce_n = '0; ab_oe_n = '0; ab_le_n = '0; a_in = 16'h3C5A; a_vld = '1;
    cycle();
    ab_le_n = '1; a_in = 16'hC3A5;
    #1;
    chk("R2 capture", b_out, 16'h3C5A);
    cycle();

    // R7: half0 transparent, half1 storing
    ab_le_n = 2'b10; a_in = 16'h9911;
    #1;
    chk("R7 independent halves", b_out, 16'h3C11);
    cycle();

    // R8: bus hold feeds a latch, value surfaces after output enable drops
    ab_le_n = '0; ab_oe_n = '1; a_in = 16'h6D2B; a_vld = '1;
    cycle();
    a_vld = '0; a_in = 16'h0000;
    cycle();
    ab_le_n = '1; a_in = 16'hFFFF; a_vld = '1;
    cycle();
    ab_oe_n = '0;
    #1;
    chk("R8 held value latched", b_out, 16'h6D2B);
    cycle();

    for (int i = 0; i < 3000; i++) begin
      ab_ce_n = NHALF'($urandom); ab_le_n = NHALF'($urandom); ab_oe_n = NHALF'($urandom);
      ba_ce_n = NHALF'($urandom); ba_le_n = NHALF'($urandom); ba_oe_n = NHALF'($urandom);
      a_in = W'($urandom); b_in = W'($urandom);
      a_vld = W'($urandom) | W'($urandom);
      b_vld = W'($urandom) | W'($urandom);
      cycle();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule